// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two request lines toward a processor core: a normal request and a fast request. Each line has its own enable mask, so one raw source vector can be steered to the normal line, the fast line, both or neither. Software changes each mask only through a pair of addresses. One address sets the bits written as 1, and the other clears the bits written as 1. Nothing ever overwrites a whole mask in one write.

Source 0 can also be raised by software, which is useful for inter-task signalling. The raw level of source 0 is the external line ORed with a software-pending bit. Software reads the raw level, the masked status of each line and each enable mask over a simple 32-bit bus addressed by word index, with read and write strobes. Read data is registered. Sources are held by their owners until serviced, and the block performs no edge detection, priority encoding or vectoring.

Top module: `dual_mask_intc`

## Requirements
- R1: After reset, both enable masks and the software-pending bit are zero, both request outputs are low, and the read data is zero.
- R2: A read of index 1 or index 9 returns the raw level. The raw level is the source vector sampled at the previous clock edge, with bit 0 ORed with the software-pending bit.
- R3: A write to index 2 ORs the write data into the normal-line enable mask. A read of index 2 returns that mask.
- R4: A write to index 3 clears every normal-line enable bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A read of index 0 returns the raw level ANDed with the normal-line enable mask.
- R6: The fast line behaves the same way at its own indices: a write to index 10 sets enable bits, a write to index 11 clears them, a read of index 10 returns the fast mask, and a read of index 8 returns the raw level ANDed with the fast mask.
- R7: A write to index 4 with data bit 0 = 1 sets the software-pending bit. A write to index 5 with data bit 0 = 1 clears it. A write to either index with data bit 0 = 0 changes nothing. A read of index 4 returns the raw level bit 0 in bit 0 and zeros in bits 31:1.
- R8: irq_o is high exactly when the raw level ANDed with the normal mask is nonzero, and fiq_o is high exactly when the raw level ANDed with the fast mask is nonzero. Each output reflects a write or a source change from the first clock edge after it.
- R9: Reads of indices 3, 5, 6, 7, 11 and 12 to 15 return zero. Writes to indices 0, 1, 6, 7, 8, 9 and 12 to 15 change no state.
- R10: rd_data_o is loaded at the clock edge where rd_en_i is high and holds its value otherwise. A read in the same cycle as a write returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-held interrupt source lines |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Word index of the register accessed |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every piece of state sits one register away from the pins. A source change, a mask write or a software-pending write therefore shows on irq_o and fiq_o just after the next rising edge, and a read strobe presented before an edge yields rd_data_o just after that same edge. The bench drives inputs on the falling edge and updates its own model at the rising edge. It computes expected read data from the model state before that update, then compares both request lines and the read data a fraction of a period after the edge. It does this on every cycle, so a result that arrives a cycle early or late, or that changes when no read was made, is caught.

// File: rtl/dmi_pkg.sv
package dmi_pkg;
  localparam int unsigned IX_IRQ_STAT = 0;
  localparam int unsigned IX_RAW      = 1;
  localparam int unsigned IX_IRQ_SET  = 2;
  localparam int unsigned IX_IRQ_CLR  = 3;
  localparam int unsigned IX_SW_SET   = 4;
  localparam int unsigned IX_SW_CLR   = 5;
  localparam int unsigned IX_FIQ_STAT = 8;
  localparam int unsigned IX_FIQ_RAW  = 9;
  localparam int unsigned IX_FIQ_SET  = 10;
  localparam int unsigned IX_FIQ_CLR  = 11;
  localparam int unsigned N_LINES     = 2;
  localparam int unsigned LINE_IRQ    = 0;
  localparam int unsigned LINE_FIQ    = 1;
endpackage

// File: rtl/dmi_mask_bank.sv
module dmi_mask_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  assign mask_en = set_i | clr_i;

  always_comb begin
    mask_d = mask_q;
    if (set_i)      mask_d = mask_q | val_i;
    else if (clr_i) mask_d = mask_q & ~val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // The same bank serves the fast line (R6).
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((mask_o & $past(val_i)) == $past(val_i))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> ((mask_o & $past(val_i)) == '0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(mask_o)); // R9
endmodule

// File: rtl/dmi_level_src.sv
module dmi_level_src #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         sw_set_i,
  input  logic         sw_clr_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] src_q;
  logic         sw_q, sw_d;

  always_comb begin
    sw_d = sw_q;
    if (sw_set_i)      sw_d = 1'b1;
    else if (sw_clr_i) sw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      src_q <= src_i;
      if (sw_set_i | sw_clr_i) sw_q <= sw_d;
    end
  end

  assign level_o = {src_q[W-1:1], src_q[0] | sw_q};

  AST_SW_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_i |=> level_o[0]); // R7
  AST_SW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !sw_set_i) |=> (level_o[0] == $past(src_i[0]))); // R7
  AST_RAW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_o[W-1:1] == $past(src_i[W-1:1]))); // R2
endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wr_data_i,
  output logic [NSRC-1:0]   rd_data_o,
  output logic              irq_o,
  output logic              fiq_o
);
  import dmi_pkg::*;

  localparam logic [ADDR_W-1:0] A_IRQ_STAT = ADDR_W'(IX_IRQ_STAT);
  localparam logic [ADDR_W-1:0] A_RAW      = ADDR_W'(IX_RAW);
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = ADDR_W'(IX_IRQ_SET);
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = ADDR_W'(IX_IRQ_CLR);
  localparam logic [ADDR_W-1:0] A_SW_SET   = ADDR_W'(IX_SW_SET);
  localparam logic [ADDR_W-1:0] A_SW_CLR   = ADDR_W'(IX_SW_CLR);
  localparam logic [ADDR_W-1:0] A_FIQ_STAT = ADDR_W'(IX_FIQ_STAT);
  localparam logic [ADDR_W-1:0] A_FIQ_RAW  = ADDR_W'(IX_FIQ_RAW);
  localparam logic [ADDR_W-1:0] A_FIQ_SET  = ADDR_W'(IX_FIQ_SET);
  localparam logic [ADDR_W-1:0] A_FIQ_CLR  = ADDR_W'(IX_FIQ_CLR);

  logic [N_LINES-1:0] set_hit, clr_hit;
  logic [NSRC-1:0]    mask [N_LINES];
  logic [N_LINES-1:0] req;
  logic [NSRC-1:0]    level;
  logic               sw_set, sw_clr;
  logic [NSRC-1:0]    rd_d, rd_q;

  assign set_hit[LINE_IRQ] = wr_en_i && (addr_i == A_IRQ_SET);
  assign clr_hit[LINE_IRQ] = wr_en_i && (addr_i == A_IRQ_CLR);
  assign set_hit[LINE_FIQ] = wr_en_i && (addr_i == A_FIQ_SET);
  assign clr_hit[LINE_FIQ] = wr_en_i && (addr_i == A_FIQ_CLR);
  assign sw_set = wr_en_i && (addr_i == A_SW_SET) && wr_data_i[0];
  assign sw_clr = wr_en_i && (addr_i == A_SW_CLR) && wr_data_i[0];

  dmi_level_src #(.W(NSRC)) u_level (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .sw_set_i(sw_set), .sw_clr_i(sw_clr), .level_o(level)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    dmi_mask_bank #(.W(NSRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_hit[g]), .clr_i(clr_hit[g]),
      .val_i(wr_data_i), .mask_o(mask[g])
    );
    assign req[g] = |(level & mask[g]);
  end

  assign irq_o = req[LINE_IRQ];
  assign fiq_o = req[LINE_FIQ];

  always_comb begin
    rd_d = '0;
    unique case (addr_i)
      A_IRQ_STAT: rd_d = level & mask[LINE_IRQ];
      A_RAW:      rd_d = level;
      A_IRQ_SET:  rd_d = mask[LINE_IRQ];
      A_SW_SET:   rd_d = {{(NSRC-1){1'b0}}, level[0]};
      A_FIQ_STAT: rd_d = level & mask[LINE_FIQ];
      A_FIQ_RAW:  rd_d = level;
      A_FIQ_SET:  rd_d = mask[LINE_FIQ];
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask[LINE_IRQ] != '0)); // R8
  AST_FIQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (mask[LINE_FIQ] != '0)); // R8
  AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (addr_i == A_IRQ_STAT || addr_i == A_FIQ_STAT))
      |=> ($stable(mask[LINE_IRQ]) && $stable(mask[LINE_FIQ]))); // R9
  AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (addr_i == A_IRQ_CLR || addr_i == A_SW_CLR || addr_i == A_FIQ_CLR))
      |=> (rd_data_o == '0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R10
endmodule

// File: tb/tb_dual_mask_intc.sv
module tb_dual_mask_intc;
  logic        clk, rst_n, wr_en, rd_en, irq, fiq;
  logic [3:0]  addr;
  logic [31:0] src, wdata, rdata;

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] m_src, m_ie, m_fe, m_rd;
  logic        m_sw;

  dual_mask_intc dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] f_level();
    return {m_src[31:1], m_src[0] | m_sw};
  endfunction

  function automatic logic [31:0] f_read(input logic [3:0] a);
    case (a)
      4'd0:  return f_level() & m_ie;
      4'd1:  return f_level();
      4'd2:  return m_ie;
      4'd4:  return {31'd0, f_level()[0]};
      4'd8:  return f_level() & m_fe;
      4'd9:  return f_level();
      4'd10: return m_fe;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string f_tag(input logic [3:0] a);
    case (a)
      4'd0: return "R5";
      4'd1, 4'd9: return "R2";
      4'd2: return "R3";
      4'd4: return "R7";
      4'd8, 4'd10: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, model at posedge, compare shortly after.
  task automatic step(input logic w, input logic r, input logic [3:0] a,
                      input logic [31:0] d, input logic [31:0] s);
    string tg;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; src = s;
    @(posedge clk);
    tg = r ? f_tag(a) : "R10";
    if (r) m_rd = f_read(a);
    if (w) begin
      case (a)
        4'd2:  m_ie = m_ie | d;
        4'd3:  m_ie = m_ie & ~d;
        4'd4:  if (d[0]) m_sw = 1'b1;
        4'd5:  if (d[0]) m_sw = 1'b0;
        4'd10: m_fe = m_fe | d;
        4'd11: m_fe = m_fe & ~d;
        default: ;
      endcase
    end
    m_src = s;
    #2;
    check(tg, rdata, m_rd);
    check("R8 irq", {31'd0, irq}, {31'd0, |(f_level() & m_ie)});
    check("R8 fiq", {31'd0, fiq}, {31'd0, |(f_level() & m_fe)});
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; src = 0;
    m_src = 0; m_ie = 0; m_fe = 0; m_rd = 0; m_sw = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 rd", rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 fiq", {31'd0, fiq}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    // R1: masks read zero after reset
    step(0, 1, 4'd2, 0, 32'hffff_ffff);
    step(0, 1, 4'd10, 0, 32'hffff_ffff);
    // R3/R4 directed
    step(1, 0, 4'd2, 32'h8000_0001, 32'h8000_0000);
    step(1, 0, 4'd3, 32'h8000_0000, 32'h8000_0000);
    step(0, 1, 4'd2, 0, 32'h8000_0000);
    // R9: writes to status indices do not touch state
    step(1, 0, 4'd0, 32'hffff_ffff, 0);
    step(1, 0, 4'd8, 32'hffff_ffff, 0);
    step(1, 0, 4'd1, 32'hffff_ffff, 0);
    step(0, 1, 4'd10, 0, 0);
    // R7: software pending drives irq via bit 0
    step(1, 0, 4'd4, 32'h0000_0001, 0);
    step(0, 1, 4'd4, 0, 0);
    step(1, 0, 4'd4, 32'h0000_0000, 0);
    step(1, 0, 4'd5, 32'hffff_fffe, 0);
    step(0, 1, 4'd1, 0, 0);
    step(1, 0, 4'd5, 32'h0000_0001, 32'h1);
    step(0, 1, 4'd4, 0, 0);
    // R6: fast line
    step(1, 0, 4'd10, 32'h00f0_0000, 32'h0010_0000);
    step(0, 1, 4'd8, 0, 0);
    step(1, 1, 4'd11, 32'h0010_0000, 32'h0010_0000);
    // R9 invalid reads; R10 read and write in the same cycle
    step(0, 1, 4'd3, 0, 32'hffff_ffff);
    step(0, 1, 4'd5, 0, 32'hffff_ffff);
    step(0, 1, 4'd11, 0, 32'hffff_ffff);
    step(0, 1, 4'd15, 0, 32'hffff_ffff);
    step(1, 1, 4'd2, 32'h0000_ff00, 32'h0000_0100);
    step(0, 1, 4'd2, 0, 32'h0000_0100);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] s, d;
      s = $urandom() & $urandom() & $urandom();
      d = ($urandom_range(0, 3) == 0) ? $urandom() : (32'd1 << $urandom_range(0, 31));
      step($urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 15)), d, s);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule